// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This peripheral keeps a free-running up-counter for an operating system. The counter advances by one on every cycle in which the tick-enable input is high; that input carries a 50 MHz timebase derived elsewhere. Software loads a single compare value. When the counter steps onto that value and the interrupt-enable register holds anything other than zero, a sticky status flag is set and a level interrupt goes high. The flag stays set until software writes zero to the status register.

Comparison is modulo 2^CNT_W, with a default CNT_W of 32. If a compare value is written that does not lie ahead of the current count, it fires only after the counter wraps through its all-ones value. Access is through a plain word-wide register port. Reads are combinational from the registers, and a write lands on the rising clock edge. Register offsets are: compare value 0x00 (write-only, reads zero), counter 0x10 (read-only), status 0x14, and interrupt enable 0x1C. Status is bit 0 of offset 0x14. Every access is a full 32-bit word.

Top module: `ostmr_top`

## Requirements
- R1: After a synchronous reset the counter, compare value, status and enable are zero, so reads of 0x10, 0x14 and 0x1C return 0 and irq_out is low.
- R2: The counter at offset 0x10 grows by exactly one per rising edge with tick_en high and holds its value otherwise. The value read is zero-extended to 32 bits.
- R3: On the rising edge where tick_en moves the counter onto the compare value while the enable register is nonzero, status bit 0 at offset 0x14 becomes 1 and irq_out goes high.
- R4: A match that happens while the enable register is zero leaves status at 0 and irq_out low.
- R5: irq_out always equals the status bit. Once set, it stays set through later ticks, later matches and clearing of the enable register, until a clear.
- R6: A write of 0 to offset 0x14 clears status and drops irq_out at the following edge. A nonzero write to 0x14 has no effect.
- R7: A compare value equal to or below the current count fires only after the counter wraps past its all-ones value, modulo 2^CNT_W.
- R8: A compare write takes effect at the next edge and re-arms detection. The new value fires, and the earlier value no longer does.
- R9: Reads of offsets other than 0x10, 0x14 and 0x1C return 0. Writes to undefined offsets and to the counter offset 0x10 change no register.
- R10: If a match and a clearing write to 0x14 happen in the same cycle, status stays set.
- R11: The enable register at 0x1C keeps and returns the full 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase pulse; the counter advances when high |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| irq_out | output | 1 | Level interrupt, equal to the status bit |

## Verification
The bench runs with a narrow counter so that wraparound can be reached. It loads compare values at, below and above the live count. A design that compares with ordering instead of equality, or that fires on the value it already holds, would raise the flag at once rather than after a full lap. The bench also clears status in the very cycle a new match arrives, which catches a design that lets the clear take priority. It rewrites the compare value between two pending points, which exposes a design that keeps a stale target armed. Writes to the counter offset and to unused offsets must leave every readable register unchanged. A nonzero write to the status register must not clear it.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;

    typedef enum logic [2:0] {
        SEL_CMP,
        SEL_COUNT,
        SEL_FLAG,
        SEL_IEN,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CMP:   return SEL_CMP;
            OFS_COUNT: return SEL_COUNT;
            OFS_FLAG:  return SEL_FLAG;
            OFS_IEN:   return SEL_IEN;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;

    assign count_nx = count_q + CNT_W'(1);
    assign hit      = tick_en && (count_nx == cmp_val);
    assign count    = count_q;

    always_ff @(posedge clk) begin
        if (rst)          count_q <= '0;
        else if (tick_en) count_q <= count_nx;
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> count_q == $past(count_q) + CNT_W'(1));
    assert_count_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(count_q));
    assert_hit_lands_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> count_q == $past(cmp_val));
endmodule

// File: rtl/ostmr_status.sv
module ostmr_status (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic ien_nz,
    input  logic clr_req,
    output logic flag
);
    logic flag_q;
    logic set_now;

    assign set_now = hit && ien_nz;
    assign flag    = flag_q;

    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_now) flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
    end

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_req) |=> flag_q);
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !flag_q);
    assert_match_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (hit && ien_nz) |=> flag_q);
    assert_no_set_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !ien_nz) |=> !flag_q);
endmodule

// File: rtl/ostmr_regfile.sv
module ostmr_regfile
    import ostmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              ien_nz,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    logic [CNT_W-1:0]  cmp_q;
    logic [DATA_W-1:0] ien_q;
    reg_sel_e          which;
    logic              wr;

    assign which   = decode_ofs(req.addr);
    assign wr      = req.sel && req.we;
    assign cmp_val = cmp_q;
    assign ien_nz  = |ien_q;
    assign clr_req = wr && (which == SEL_FLAG) && (req.wdata == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
            ien_q <= '0;
        end else if (wr) begin
            if (which == SEL_CMP) cmp_q <= req.wdata[CNT_W-1:0];
            if (which == SEL_IEN) ien_q <= req.wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.sel && !req.we) begin
            case (which)
                SEL_COUNT: rdata = DATA_W'(count);
                SEL_FLAG:  rdata = DATA_W'(flag);
                SEL_IEN:   rdata = ien_q;
                default:   rdata = '0;
            endcase
        end
    end

    assert_cmp_only_by_write_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr && which == SEL_CMP) |=> $stable(cmp_q));
    assert_ien_only_by_write_R11: assert property (@(posedge clk) disable iff (rst)
        !(wr && which == SEL_IEN) |=> $stable(ien_q));
endmodule

// File: rtl/ostmr_top.sv
module ostmr_top
    import ostmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    bus_req_t         req;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] count;
    logic             hit;
    logic             ien_nz;
    logic             clr_req;
    logic             flag;

    assign req     = '{sel: bus_sel, we: bus_we, addr: bus_addr, wdata: bus_wdata};
    assign irq_out = flag;

    ostmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .cmp_val(cmp_val), .count(count), .hit(hit)
    );

    ostmr_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .count(count), .flag(flag),
        .cmp_val(cmp_val), .ien_nz(ien_nz), .clr_req(clr_req), .rdata(bus_rdata)
    );

    ostmr_status u_stat (
        .clk(clk), .rst(rst), .hit(hit), .ien_nz(ien_nz),
        .clr_req(clr_req), .flag(flag)
    );

    initial begin
        assert_width_R7: assert (CNT_W >= 2 && CNT_W <= DATA_W);
    end
endmodule

// File: tb/sim_ostmr_top.sv
module sim_ostmr_top;
    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    int cnt_exp = 0;

    ostmr_top #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #4 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick_en = 1'b0;
        if (tk) cnt_exp = (cnt_exp + 1) & MASK;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        cnt_exp = (cnt_exp + n) & MASK;
    endtask

    task automatic check_flag(input string tag, input logic exp);
        logic [31:0] v;
        rd(8'h14, v);
        check({tag, " status"}, v, {31'd0, exp});
        check({tag, " irq"}, {31'd0, irq_out}, {31'd0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h10, v); check("R1 counter", v, 0);
        rd(8'h1C, v); check("R1 enable", v, 0);
        check_flag("R1", 1'b0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        ticks(5);
        rd(8'h10, v); check("R2 after 5 ticks", v, 5);
        repeat (3) @(negedge clk);
        rd(8'h10, v); check("R2 hold", v, 5);
    endtask

    task automatic t_match();
        wr(8'h1C, 32'd1, 1'b0);
        wr(8'h00, (cnt_exp + 4) & MASK, 1'b0);
        ticks(3);
        check_flag("R3 before", 1'b0);
        ticks(1);
        check_flag("R3 on match", 1'b1);
        ticks(7);
        check_flag("R5 later ticks", 1'b1);
        wr(8'h1C, 32'd0, 1'b0);
        check_flag("R5 enable off", 1'b1);
        wr(8'h14, 32'd5, 1'b0);
        check_flag("R6 nonzero write", 1'b1);
        wr(8'h14, 32'd0, 1'b0);
        check_flag("R6 cleared", 1'b0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(8'h00, (cnt_exp + 3) & MASK, 1'b0);
        ticks(3);
        check_flag("R4 disabled match", 1'b0);
        wr(8'h1C, 32'hA5A5_0001, 1'b0);
        rd(8'h1C, v); check("R11 enable readback", v, 32'hA5A5_0001);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int target;
        target = (cnt_exp - 2) & MASK;
        wr(8'h00, target, 1'b0);
        ticks(MASK - 2);
        check_flag("R7 below, before wrap", 1'b0);
        ticks(1);
        check_flag("R7 below, after wrap", 1'b1);
        rd(8'h10, v); check("R7 counter at target", v, target);
        wr(8'h14, 32'd0, 1'b0);
        wr(8'h00, cnt_exp, 1'b0);
        ticks(MASK);
        check_flag("R7 equal, one short", 1'b0);
        ticks(1);
        check_flag("R7 equal, full lap", 1'b1);
        wr(8'h14, 32'd0, 1'b0);
    endtask

    task automatic t_rearm();
        int old_t;
        old_t = (cnt_exp + 5) & MASK;
        wr(8'h00, old_t, 1'b0);
        ticks(2);
        wr(8'h00, (cnt_exp + 10) & MASK, 1'b0);
        ticks(3);
        check_flag("R8 old value passed", 1'b0);
        ticks(6);
        check_flag("R8 one before new", 1'b0);
        ticks(1);
        check_flag("R8 new value fires", 1'b1);
        wr(8'h14, 32'd0, 1'b0);
    endtask

    task automatic t_undef();
        logic [31:0] v;
        wr(8'h10, 32'h0000_0123, 1'b0);
        rd(8'h10, v); check("R9 counter not writable", v, cnt_exp);
        wr(8'h18, 32'hFFFF_FFFF, 1'b0);
        wr(8'h04, 32'hFFFF_FFFF, 1'b0);
        rd(8'h1C, v); check("R9 enable untouched", v, 32'hA5A5_0001);
        check_flag("R9 status untouched", 1'b0);
        rd(8'h04, v); check("R9 read 0x04", v, 0);
        rd(8'h18, v); check("R9 read 0x18", v, 0);
        rd(8'h00, v); check("R9 compare write-only", v, 0);
    endtask

    task automatic t_collide();
        wr(8'h00, (cnt_exp + 2) & MASK, 1'b0);
        ticks(2);
        check_flag("R10 first set", 1'b1);
        wr(8'h00, (cnt_exp + 1) & MASK, 1'b0);
        wr(8'h14, 32'd0, 1'b1);
        check_flag("R10 match beats clear", 1'b1);
        wr(8'h14, 32'd0, 1'b0);
        check_flag("R10 later clear", 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_count();
                t_match();
                t_disabled();
                t_wrap();
                t_rearm();
                t_undef();
                t_collide();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule